// File: doc/BRIEF.md
# Hamming-Coded Asynchronous Serial Transmitter

This block turns one parallel data word into an asynchronous serial frame on a single line. The word is 8, 16 or 32 bits wide, chosen per frame. The frame opens with a low start bit and closes with a high stop bit. Between them the block sends a protected codeword in one of two forms. In single-parity mode, the data goes out least significant bit first, followed by one even-parity bit. In Hamming mode, check bits sit at the power-of-two codeword positions and the data bits fill the positions between them. A receiver can then locate and flip any one corrupted bit without asking for a resend.

The bit period comes from a 16-bit divisor of the block clock. Each line bit lasts divisor+1 clock cycles, so the rate runs from the full clock down to the clock divided by 65536. A host presents a word on `dataIn` together with `widthSel`, `hamMode` and `baudDiv`, and raises `loadValid`. The word is taken on the first clock edge where `loadReady` is high. Width, mode and divisor are captured at that edge and are used for the whole frame. `busy` stays high until the stop bit has finished.

Top module: `hamUartTx`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `txLine` is 1, `busy` is 0 and `loadReady` is 1.
- R2: A word is accepted only on a clock edge where `loadValid` and `loadReady` are both 1. While `busy` is 1, `loadReady` is 0, and `loadValid` has no effect on the frame being sent or on any later frame.
- R3: Every line bit, start and stop bits included, lasts exactly `baudDiv`+1 clock cycles.
- R4: A frame is a start bit of 0, then codeword positions 1 upward in order, then a stop bit of 1. `txLine` shows the start bit from the cycle after the accepting edge. `busy` is high for exactly L×(`baudDiv`+1) cycles, where L is the number of line bits.
- R5: In Hamming mode (`hamMode`=1), the codeword positions that are powers of two (1, 2, 4, 8, 16, 32) carry check bits. All other positions carry data bit 0 upward, in ascending order.
- R6: In Hamming mode, the check bit at position 2^k is the XOR of all other codeword positions whose index has bit k set. The XOR over all positions that have bit k set is therefore 0.
- R7: `widthSel` encodes the word width: 0 means 8 bits, 1 means 16 bits, and both 2 and 3 mean 32 bits. In Hamming mode L is 14, 23 or 40.
- R8: In single-parity mode (`hamMode`=0), the codeword is the data bits, least significant first, followed by one even-parity bit over the data. L is 11, 19 or 35.
- R9: `widthSel`, `hamMode` and `baudDiv` are sampled only at the accepting edge. Changing them during a frame does not alter its bits or timing.
- R10: Bits of `dataIn` above the selected width are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadValid | input | 1 | Host offers a word |
| loadReady | output | 1 | Transmitter idle, a word can be taken |
| dataIn | input | 32 | Data word, the low bits used for narrower widths |
| widthSel | input | 2 | Word width: 0 = 8, 1 = 16, 2 or 3 = 32 |
| hamMode | input | 1 | 1 = Hamming check bits, 0 = one even-parity bit |
| baudDiv | input | 16 | Bit period minus one, in clock cycles |
| txLine | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |

## Verification
The word is taken on a rising edge. From the next cycle `txLine` carries the start bit, and line bit i begins i×(`baudDiv`+1) cycles later. `busy` falls exactly L×(`baudDiv`+1) cycles after the accepting edge. The bench counts falling edges from the accepting edge and samples every bit in the first cycle of its period. It requires the line to stay unchanged for the rest of that period. Each cycle of the frame it checks `busy` and `loadReady`, and it checks the idle state in cycle L×(`baudDiv`+1) itself. A checker counts cycles within each bit and flags any line change that falls away from a bit boundary.

// File: rtl/hamUartPkg.sv
package hamUartPkg;

  localparam int MAX_DATA_W = 32;

  // smallest number of check bits r that covers w data bits
  function automatic int checkBitsFor(input int w);
    for (int r = 1; r < 16; r++) begin
      if ((1 << r) >= w + r + 1) return r;
    end
    return 16;
  endfunction

  function automatic bit isPow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // data bit index carried by a non-power-of-two codeword position
  function automatic int dataIdxOf(input int p);
    int idx;
    idx = 0;
    for (int q = 1; q < p; q++) begin
      if (!isPow2(q)) idx++;
    end
    return idx;
  endfunction

  localparam int MAX_CHK_W   = checkBitsFor(MAX_DATA_W);
  localparam int MAX_CODE_W  = MAX_DATA_W + MAX_CHK_W;
  localparam int MAX_FRAME_W = MAX_CODE_W + 2;
  localparam int LEN_W       = $clog2(MAX_FRAME_W + 1);

  // control to datapath strobes
  typedef struct packed {
    logic load;
    logic shift;
  } txStrobeT;

endpackage

// File: rtl/hamCheckGen.sv
module hamCheckGen
  import hamUartPkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int CODE_W = DATA_W + checkBitsFor(DATA_W)
) (
  input  logic [DATA_W-1:0] dataVec,
  output logic [CODE_W-1:0] codeVec
);

  // data bits covered by check bit k
  function automatic logic [DATA_W-1:0] coverMask(input int k);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!isPow2(p) && (((p >> k) & 1) == 1)) m[dataIdxOf(p)] = 1'b1;
    end
    return m;
  endfunction

  for (genvar pos = 1; pos <= CODE_W; pos++) begin : g_pos
    if (isPow2(pos)) begin : g_chk
      localparam int K = $clog2(pos);
      localparam logic [DATA_W-1:0] MASK = coverMask(K);
      assign codeVec[pos-1] = ^(dataVec & MASK);
    end else begin : g_dat
      assign codeVec[pos-1] = dataVec[dataIdxOf(pos)];
    end
  end

endmodule

// File: rtl/hamUartDatapath.sv
module hamUartDatapath
  import hamUartPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  txStrobeT              strobe,
  input  logic [MAX_DATA_W-1:0] dataIn,
  input  logic [1:0]            widthSel,
  input  logic                  hamMode,
  output logic [LEN_W-1:0]      frameLen,
  output logic                  lineBit
);

  localparam int HAM_LEN_8  = 8  + checkBitsFor(8);
  localparam int HAM_LEN_16 = 16 + checkBitsFor(16);
  localparam int HAM_LEN_32 = 32 + checkBitsFor(32);

  logic [MAX_DATA_W-1:0]  widthMask;
  logic [MAX_DATA_W-1:0]  dataMasked;
  logic [MAX_CODE_W-1:0]  hamCode;
  logic [MAX_CODE_W-1:0]  parCode;
  logic [MAX_CODE_W-1:0]  codeSel;
  logic [LEN_W-1:0]       codeLen;
  logic [LEN_W-1:0]       dataLen;
  logic [MAX_FRAME_W-1:0] frameNext;
  logic [MAX_FRAME_W-1:0] fillMask;
  logic [MAX_FRAME_W-1:0] frameReg;

  always_comb begin
    case (widthSel)
      2'd0:    begin widthMask = MAX_DATA_W'(32'h0000_00FF); dataLen = LEN_W'(8);  end
      2'd1:    begin widthMask = MAX_DATA_W'(32'h0000_FFFF); dataLen = LEN_W'(16); end
      default: begin widthMask = '1;                         dataLen = LEN_W'(32); end
    endcase
  end

  assign dataMasked = dataIn & widthMask;

  hamCheckGen #(.DATA_W(MAX_DATA_W)) u_checkGen (
    .dataVec (dataMasked),
    .codeVec (hamCode)
  );

  always_comb begin
    parCode          = {{(MAX_CODE_W-MAX_DATA_W){1'b0}}, dataMasked};
    parCode[dataLen] = ^dataMasked;
  end

  always_comb begin
    if (hamMode) begin
      codeSel = hamCode;
      case (widthSel)
        2'd0:    codeLen = LEN_W'(HAM_LEN_8);
        2'd1:    codeLen = LEN_W'(HAM_LEN_16);
        default: codeLen = LEN_W'(HAM_LEN_32);
      endcase
    end else begin
      codeSel = parCode;
      codeLen = dataLen + LEN_W'(1);
    end
  end

  assign frameLen  = codeLen + LEN_W'(2);
  assign fillMask  = {MAX_FRAME_W{1'b1}} << (codeLen + LEN_W'(1));
  assign frameNext = {1'b0, codeSel, 1'b0} | fillMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '1;
    end else if (strobe.load) begin
      frameReg <= frameNext;
    end else if (strobe.shift) begin
      frameReg <= {1'b1, frameReg[MAX_FRAME_W-1:1]};
    end
  end

  assign lineBit = frameReg[0];

endmodule

// File: rtl/hamUartCtrl.sv
module hamUartCtrl
  import hamUartPkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadValid,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic [LEN_W-1:0] frameLen,
  output txStrobeT         strobe,
  output logic             busy
);

  typedef enum logic {ST_IDLE, ST_SEND} stateT;

  stateT            state;
  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] baudCnt;
  logic [LEN_W-1:0] bitsLeft;
  logic             bitEnd;

  assign bitEnd       = (baudCnt == divReg);
  assign strobe.load  = (state == ST_IDLE) && loadValid;
  assign strobe.shift = (state == ST_SEND) && bitEnd;
  assign busy         = (state == ST_SEND);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divReg   <= '0;
      baudCnt  <= '0;
      bitsLeft <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (loadValid) begin
            state    <= ST_SEND;
            divReg   <= baudDiv;
            baudCnt  <= '0;
            bitsLeft <= frameLen;
          end
        end
        default: begin
          if (bitEnd) begin
            baudCnt  <= '0;
            bitsLeft <= bitsLeft - LEN_W'(1);
            if (bitsLeft == LEN_W'(1)) state <= ST_IDLE;
          end else begin
            baudCnt <= baudCnt + DIV_W'(1);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/hamUartTx.sv
module hamUartTx
  import hamUartPkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  loadValid,
  output logic                  loadReady,
  input  logic [MAX_DATA_W-1:0] dataIn,
  input  logic [1:0]            widthSel,
  input  logic                  hamMode,
  input  logic [DIV_W-1:0]      baudDiv,
  output logic                  txLine,
  output logic                  busy
);

  txStrobeT         strobe;
  logic [LEN_W-1:0] frameLen;

  hamUartCtrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadValid (loadValid),
    .baudDiv   (baudDiv),
    .frameLen  (frameLen),
    .strobe    (strobe),
    .busy      (busy)
  );

  hamUartDatapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataIn   (dataIn),
    .widthSel (widthSel),
    .hamMode  (hamMode),
    .frameLen (frameLen),
    .lineBit  (txLine)
  );

  assign loadReady = !busy;

endmodule

// File: rtl/hamUartTxChk.sv
module hamUartTxChk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadValid,
  input logic             loadReady,
  input logic [DIV_W-1:0] baudDiv,
  input logic             txLine,
  input logic             busy
);

  logic [DIV_W-1:0] divCap;
  logic [DIV_W-1:0] phase;

  // cycle position within the current line bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCap <= '0;
      phase  <= '0;
    end else if (loadValid && loadReady) begin
      divCap <= baudDiv;
      phase  <= '0;
    end else if (busy) begin
      phase <= (phase == divCap) ? '0 : phase + DIV_W'(1);
    end
  end

  p_line_high_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

  p_accept_needs_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(loadValid));

  p_line_steady_in_bit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && phase != '0) |-> $stable(txLine));

  p_start_bit_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !txLine);

  p_stop_bit_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(txLine));

endmodule

bind hamUartTx hamUartTxChk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .loadValid (loadValid),
  .loadReady (loadReady),
  .baudDiv   (baudDiv),
  .txLine    (txLine),
  .busy      (busy)
);

// File: tb/test_hamUartTx.sv
`timescale 1ns/1ps
module test_hamUartTx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadValid = 1'b0;
  logic        loadReady;
  logic [31:0] dataIn = '0;
  logic [1:0]  widthSel = '0;
  logic        hamMode = 1'b0;
  logic [15:0] baudDiv = '0;
  logic        txLine;
  logic        busy;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  hamUartTx i_hamUartTx (
    .clk       (clk),
    .rstN      (rstN),
    .loadValid (loadValid),
    .loadReady (loadReady),
    .dataIn    (dataIn),
    .widthSel  (widthSel),
    .hamMode   (hamMode),
    .baudDiv   (baudDiv),
    .txLine    (txLine),
    .busy      (busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // frame length by width select and mode, taken from R7 and R8
  function automatic int lineBits(input logic [1:0] ws, input logic m);
    if (m) return (ws == 2'd0) ? 14 : (ws == 2'd1) ? 23 : 40;
    return (ws == 2'd0) ? 11 : (ws == 2'd1) ? 19 : 35;
  endfunction

  // expected line bits, index 0 = start bit
  function automatic logic [39:0] expFrame(input logic [31:0] d, input logic [1:0] ws,
                                           input logic m);
    logic [39:0] f;
    logic [63:0] cw;
    int w, n, di, pos;
    logic par;
    w = (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
    f = '1;
    f[0] = 1'b0;
    if (m) begin
      cw = '0;
      di = 0;
      pos = 0;
      while (di < w) begin
        pos++;
        if (!pow2(pos)) begin
          cw[pos] = d[di];
          di++;
        end
      end
      n = pos;
      for (int k = 0; (1 << k) <= n; k++) begin
        par = 1'b0;
        for (int q = 1; q <= n; q++) begin
          if (((q >> k) & 1) == 1 && q != (1 << k)) par ^= cw[q];
        end
        cw[1 << k] = par;
      end
      for (int q = 1; q <= n; q++) f[q] = cw[q];
    end else begin
      par = 1'b0;
      for (int i = 0; i < w; i++) begin
        f[1 + i] = d[i];
        par ^= d[i];
      end
      f[w + 1] = par;
    end
    return f;
  endfunction

  // send one word and check the whole frame at the ports
  task automatic runFrame(input logic [31:0] d, input logic [1:0] ws, input logic m,
                          input logic [15:0] dv, input bit disturb, input string req);
    logic [39:0] expBits, gotBits, lenMask;
    int len, per, steadyErr, flagErr, synErr;
    logic s;
    expBits = expFrame(d, ws, m);
    len = lineBits(ws, m);
    per = int'(dv) + 1;
    @(negedge clk);
    dataIn = d; widthSel = ws; hamMode = m; baudDiv = dv; loadValid = 1'b1;
    @(negedge clk);
    loadValid = 1'b0;
    gotBits = '1; steadyErr = 0; flagErr = 0;
    for (int c = 0; c < len * per; c++) begin
      if (c % per == 0) gotBits[c / per] = txLine;
      else if (txLine !== gotBits[c / per]) steadyErr++;
      if (busy !== 1'b1 || loadReady !== 1'b0) flagErr++;
      if (disturb && c == 1) begin
        loadValid = 1'b1; dataIn = ~d; widthSel = ws ^ 2'd1; hamMode = ~m;
        baudDiv = 16'(dv + 16'd3);
      end
      if (disturb && c == 2 * per) loadValid = 1'b0;
      @(negedge clk);
    end
    lenMask = (40'd1 << len) - 40'd1;
    check((gotBits & lenMask) === (expBits & lenMask), req, "frame bits",
          64'(gotBits & lenMask), 64'(expBits & lenMask));
    check(steadyErr == 0, "R3", "line changed inside a bit period", 64'(steadyErr), 64'd0);
    check(flagErr == 0, "R2/R4", "busy/loadReady during frame", 64'(flagErr), 64'd0);
    check(busy === 1'b0 && loadReady === 1'b1 && txLine === 1'b1, "R4/R1",
          "idle exactly at frame end", {61'd0, busy, loadReady, txLine}, 64'b011);
    if (m) begin
      synErr = 0;
      for (int k = 0; (1 << k) <= len - 2; k++) begin
        s = 1'b0;
        for (int q = 1; q <= len - 2; q++) if (((q >> k) & 1) == 1) s ^= gotBits[q];
        if (s !== 1'b0) synErr++;
      end
      check(synErr == 0, "R6", "nonzero syndrome", 64'(synErr), 64'd0);
    end
  endtask

  task automatic testReset();
    check(txLine === 1'b1 && busy === 1'b0 && loadReady === 1'b1, "R1", "reset state",
          {61'd0, txLine, busy, loadReady}, 64'b101);
  endtask

  task automatic testHam8();
    runFrame(32'h0000_00A5, 2'd0, 1'b1, 16'd0, 1'b0, "R5/R7");
    runFrame(32'h0000_0001, 2'd0, 1'b1, 16'd0, 1'b0, "R5/R6");
    runFrame(32'h0000_00FF, 2'd0, 1'b1, 16'd1, 1'b0, "R5/R6");
  endtask

  task automatic testHam16();
    runFrame(32'h0000_8001, 2'd1, 1'b1, 16'd2, 1'b0, "R5/R7");
    runFrame(32'h0000_3C5A, 2'd1, 1'b1, 16'd0, 1'b0, "R6/R7");
  endtask

  task automatic testHam32();
    runFrame(32'hDEAD_BEEF, 2'd2, 1'b1, 16'd3, 1'b0, "R5/R7");
    runFrame(32'h8000_0000, 2'd2, 1'b1, 16'd0, 1'b0, "R6/R7");
  endtask

  task automatic testWidthAlias();
    runFrame(32'h1234_5678, 2'd3, 1'b1, 16'd1, 1'b0, "R7 sel3");
    runFrame(32'h1234_5678, 2'd3, 1'b0, 16'd1, 1'b0, "R7/R8 sel3");
  endtask

  task automatic testParity();
    runFrame(32'h0000_0096, 2'd0, 1'b0, 16'd0, 1'b0, "R8 w8");
    runFrame(32'h0000_0007, 2'd0, 1'b0, 16'd2, 1'b0, "R8 w8 odd");
    runFrame(32'h0000_F00D, 2'd1, 1'b0, 16'd1, 1'b0, "R8 w16");
    runFrame(32'hCAFE_F00D, 2'd2, 1'b0, 16'd0, 1'b0, "R8 w32");
  endtask

  task automatic testUpperIgnored();
    runFrame(32'hABCD_E35A, 2'd0, 1'b1, 16'd0, 1'b0, "R10 ham8");
    runFrame(32'hFFFF_0000, 2'd1, 1'b0, 16'd0, 1'b0, "R10 par16");
  endtask

  task automatic testBusyLoad();
    runFrame(32'h0000_5A3C, 2'd1, 1'b1, 16'd2, 1'b1, "R2/R9 ham16");
    runFrame(32'h0000_00C3, 2'd0, 1'b0, 16'd1, 1'b1, "R2/R9 par8");
  endtask

  task automatic testSlowBaud();
    runFrame(32'h0000_0069, 2'd0, 1'b1, 16'd999, 1'b0, "R3 slow");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testHam8();
    testHam16();
    testHam32();
    testWidthAlias();
    testParity();
    testUpperIgnored();
    testBusyLoad();
    testSlowBaud();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule